// File: doc/BRIEF.md
# Banked GPIO Register File

This block is a memory-mapped GPIO controller. Its pins are grouped eight to a bank, and each bank has two registers: a value register and a direction register. Software reaches these registers through a simple 32-bit register-bus read/write port. The block drives the pad output values and output enables. When software reads a bank's value register, it gets back the input levels of the pads.

Each bank's register pair sits at an 8-byte slot whose address is worked out from the bank number. The slots leave a reserved 16-byte window unused. A neighbouring interrupt block decodes that window, so no bank register ever answers there. Pad inputs pass through a two-flop synchronizer before the read path uses them. Every register can be read back, so software can save the whole state and later restore it. The bank count is a parameter.

Top module: `pinbank_gpio`

## Requirements
- R1: After reset every direction bit is 1 and every stored value bit is 0. So `pad_oe` and `pad_out` are all zero, and `rd_data` is zero.
- R2: Bank b's register pair sits at base (b+1)*8. When that base is 0x90 or above, 0x10 is added. The value register is at base+0x0 and the direction register at base+0x4. Pin n is bank n/8, bit n%8.
- R3: The window 0x90 to 0x9F belongs to no bank. Reads there return zero, and writes there change no pin, output enable or register.
- R4: A direction bit of 1 makes its pin an input (`pad_oe` low). A direction bit of 0 makes it an output (`pad_oe` high).
- R5: A value register write is stored even while the pin is an input. The pin drives that value on `pad_out` as soon as its direction bit goes to 0.
- R6: A value register read returns, bit by bit, the synchronized pad level for input pins and the stored value for output pins.
- R7: A pad level change first becomes visible to a read request presented at the third rising edge after the change. Requests at the first and second edges still see the old level.
- R8: A direction register read returns the stored direction bits unchanged.
- R9: An address below 0x08, past the last bank, or with bits [1:0] not zero is unmapped. Reads there return zero, and writes there are ignored.
- R10: Writes use only `req_wdata[7:0]`. Read data bits [31:8] are always zero.
- R11: `rd_data` is loaded at the rising edge that accepts a read request. It holds its value through writes and idle cycles until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, registered |
| pad_in | input | NUM_BANKS*8 | Pad input levels (asynchronous) |
| pad_out | output | NUM_BANKS*8 | Pad output values |
| pad_oe | output | NUM_BANKS*8 | Pad output enables, 1 = drive |

## Verification
The synchronizer can advance a new pad level in the same cycle that a value register read samples the read path. The bench changes a bank's pad inputs in the same cycle it raises a read request to that bank. It then holds the request for three edges and expects the old level twice and the new level on the third. A second collision is a direction write that turns a pin around. The bench expects the next read of that bank to take the stored value for output bits and the pad level for the bits still set as inputs.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  localparam int unsigned PINS_PER_BANK = 8;
  localparam int unsigned BANK_STRIDE   = 8;
  localparam int unsigned HOLE_BASE     = 'h90;
  localparam int unsigned HOLE_SIZE     = 'h10;

  typedef enum logic {
    SEL_VALUE = 1'b0,
    SEL_DIR   = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/pinbank_decode.sv
module pinbank_decode
  import pinbank_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 20,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned IDX_W     = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output reg_sel_e          sel,
  output logic [IDX_W-1:0]  bank_idx
);
  localparam int unsigned SLOT_W = ADDR_W - 3;
  localparam logic [SLOT_W-1:0] HOLE_LO = SLOT_W'(HOLE_BASE / BANK_STRIDE);
  localparam logic [SLOT_W-1:0] HOLE_HI = SLOT_W'((HOLE_BASE + HOLE_SIZE) / BANK_STRIDE);
  localparam logic [SLOT_W-1:0] SKIP    = SLOT_W'(HOLE_SIZE / BANK_STRIDE);
  localparam logic [SLOT_W-1:0] NB      = SLOT_W'(NUM_BANKS);

  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] cand;
  logic              in_map;

  assign slot = addr[ADDR_W-1:3];

  always_comb begin
    cand   = '0;
    in_map = 1'b0;
    if (slot != '0 && slot < HOLE_LO) begin
      cand   = slot - SLOT_W'(1);
      in_map = 1'b1;
    end else if (slot >= HOLE_HI) begin
      cand   = slot - SLOT_W'(1) - SKIP;
      in_map = 1'b1;
    end
  end

  assign hit      = in_map && (addr[1:0] == 2'b00) && (cand < NB);
  assign sel      = addr[2] ? SEL_DIR : SEL_VALUE;
  assign bank_idx = cand[IDX_W-1:0];
endmodule

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/pinbank_bank.sv
module pinbank_bank #(
  parameter int unsigned PINS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            value_we,
  input  logic            dir_we,
  input  logic [PINS-1:0] wdata,
  output logic [PINS-1:0] value_q,
  output logic [PINS-1:0] dir_q
);
  logic [PINS-1:0] value_d;
  logic [PINS-1:0] dir_d;

  always_comb begin
    value_d = value_q;
    dir_d   = dir_q;
    if (value_we) value_d = wdata;
    if (dir_we)   dir_d   = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q <= '0;
      dir_q   <= '1;
    end else begin
      if (value_we) value_q <= value_d;
      if (dir_we)   dir_q   <= dir_d;
    end
  end
endmodule

// File: rtl/pinbank_gpio.sv
module pinbank_gpio
  import pinbank_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 20,
  parameter int unsigned ADDR_W    = 12,
  localparam int unsigned NPINS    = NUM_BANKS * PINS_PER_BANK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rd_data,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe
);
  localparam int unsigned IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int unsigned PPB   = PINS_PER_BANK;

  logic             hit;
  reg_sel_e         sel;
  logic [IDX_W-1:0] bank_idx;
  logic [NPINS-1:0] pad_sync;
  logic [PPB-1:0]   value_arr [NUM_BANKS];
  logic [PPB-1:0]   dir_arr   [NUM_BANKS];
  logic [PPB-1:0]   sync_arr  [NUM_BANKS];
  logic             wr_acc;
  logic             rd_acc;
  logic [31:0]      rd_d;
  logic [31:0]      rd_q;

  pinbank_decode #(
    .NUM_BANKS(NUM_BANKS),
    .ADDR_W   (ADDR_W),
    .IDX_W    (IDX_W)
  ) u_decode (
    .addr    (req_addr),
    .hit     (hit),
    .sel     (sel),
    .bank_idx(bank_idx)
  );

  pinbank_sync #(.W(NPINS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pad_in),
    .q    (pad_sync)
  );

  assign wr_acc = req_valid && req_write && hit;
  assign rd_acc = req_valid && !req_write;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel_me;
    assign sel_me = wr_acc && (bank_idx == IDX_W'(b));

    pinbank_bank #(.PINS(PPB)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .value_we(sel_me && (sel == SEL_VALUE)),
      .dir_we  (sel_me && (sel == SEL_DIR)),
      .wdata   (req_wdata[PPB-1:0]),
      .value_q (value_arr[b]),
      .dir_q   (dir_arr[b])
    );

    assign sync_arr[b]             = pad_sync[b*PPB +: PPB];
    assign pad_out[b*PPB +: PPB]   = value_arr[b];
    assign pad_oe[b*PPB +: PPB]    = ~dir_arr[b];
  end

  always_comb begin
    rd_d = '0;
    if (hit) begin
      if (sel == SEL_DIR) begin
        rd_d[PPB-1:0] = dir_arr[bank_idx];
      end else begin
        rd_d[PPB-1:0] = (dir_arr[bank_idx] & sync_arr[bank_idx]) |
                        (~dir_arr[bank_idx] & value_arr[bank_idx]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_acc) begin
      rd_q <= rd_d;
    end
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/pinbank_gpio_chk.sv
module pinbank_gpio_chk #(
  parameter int unsigned NPINS  = 160,
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       rd_data,
  input logic [NPINS-1:0]  pad_out,
  input logic [NPINS-1:0]  pad_oe
);
  logic in_hole;
  assign in_hole = (req_addr >= ADDR_W'('h90)) && (req_addr < ADDR_W'('hA0));

  // R4: output enables move only after an accepted write
  p_oe_needs_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pad_oe) |-> $past(req_valid && req_write));

  // R5: driven values move only after an accepted write
  p_out_needs_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pad_out) |-> $past(req_valid && req_write));

  // R10: upper read bits stay zero
  p_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31:8] == 24'h0);

  // R11: read data held when no read was accepted
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid && !req_write) |-> $stable(rd_data));

  // R3: reads inside the reserved window return zero
  p_hole_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && in_hole) |=> (rd_data == 32'h0));

  // R3: writes inside the reserved window touch no pin
  p_hole_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && in_hole) |=> ($stable(pad_out) && $stable(pad_oe)));
endmodule

bind pinbank_gpio pinbank_gpio_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_write(req_write),
  .req_addr (req_addr),
  .rd_data  (rd_data),
  .pad_out  (pad_out),
  .pad_oe   (pad_oe)
);

// File: tb/pinbank_gpio_tb.sv
module pinbank_gpio_tb;
  localparam int NB    = 20;
  localparam int AW    = 12;
  localparam int NPINS = NB * 8;
  localparam int NVEC  = 33;

  // {write, addr[11:0], wdata[7:0], expected[7:0]}
  localparam logic [28:0] VEC [NVEC] = '{
    {1'b0, 12'h00C, 8'h00, 8'hFF},  // R1 R8 dir reset
    {1'b0, 12'h008, 8'h00, 8'h3C},  // R6 all inputs
    {1'b1, 12'h008, 8'hF0, 8'h00},  // R5 prewrite
    {1'b0, 12'h008, 8'h00, 8'h3C},  // R5 still inputs
    {1'b1, 12'h00C, 8'h0F, 8'h00},  // R4 upper nibble out
    {1'b0, 12'h008, 8'h00, 8'hFC},  // R6 mixed
    {1'b0, 12'h00C, 8'h00, 8'h0F},  // R8
    {1'b1, 12'h088, 8'h55, 8'h00},  // R2 bank16
    {1'b1, 12'h08C, 8'h00, 8'h00},
    {1'b0, 12'h088, 8'h00, 8'h55},  // R2
    {1'b1, 12'h0A0, 8'h81, 8'h00},  // R2 bank17 past window
    {1'b1, 12'h0A4, 8'h00, 8'h00},
    {1'b0, 12'h0A0, 8'h00, 8'h81},  // R2
    {1'b1, 12'h090, 8'hFF, 8'h00},  // R3 hole write
    {1'b1, 12'h094, 8'hFF, 8'h00},  // R3
    {1'b0, 12'h090, 8'h00, 8'h00},  // R3 hole read
    {1'b0, 12'h094, 8'h00, 8'h00},  // R3
    {1'b0, 12'h088, 8'h00, 8'h55},  // R3 neighbour kept
    {1'b0, 12'h08C, 8'h00, 8'h00},  // R3
    {1'b0, 12'h0A0, 8'h00, 8'h81},  // R3
    {1'b0, 12'h0A4, 8'h00, 8'h00},  // R3
    {1'b1, 12'h0B4, 8'h00, 8'h00},  // R2 last bank
    {1'b1, 12'h0B0, 8'h12, 8'h00},
    {1'b0, 12'h0B0, 8'h00, 8'h12},  // R2
    {1'b1, 12'h0B8, 8'hFF, 8'h00},  // R9 past end
    {1'b0, 12'h0B8, 8'h00, 8'h00},  // R9
    {1'b0, 12'h000, 8'h00, 8'h00},  // R9 below first
    {1'b1, 12'h004, 8'hFF, 8'h00},  // R9
    {1'b0, 12'h004, 8'h00, 8'h00},  // R9
    {1'b0, 12'h080, 8'h00, 8'h3C},  // R2 bank15 input
    {1'b0, 12'h084, 8'h00, 8'hFF},  // R8
    {1'b1, 12'h09C, 8'hFF, 8'h00},  // R3
    {1'b0, 12'h0B4, 8'h00, 8'h00}   // R8 last bank dir
  };

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic              req_write;
  logic [AW-1:0]     req_addr;
  logic [31:0]       req_wdata;
  logic [31:0]       rd_data;
  logic [NPINS-1:0]  pad_in;
  logic [NPINS-1:0]  pad_out;
  logic [NPINS-1:0]  pad_oe;

  int checks;
  int errors;
  bit done;

  pinbank_gpio #(.NUM_BANKS(NB), .ADDR_W(AW)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .rd_data  (rd_data),
    .pad_in   (pad_in),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [NPINS-1:0] act,
                       input logic [NPINS-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rd_data;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [31:0] last;
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0;
    pad_in = {NB{8'h3C}};
    repeat (4) @(negedge clk);
    check("R1 pad_oe", pad_oe, '0);
    check("R1 pad_out", pad_out, '0);
    check("R1 rd_data", NPINS'(rd_data), '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][28]) begin
        bus_write(VEC[i][27:16], {24'h0, VEC[i][15:8]});
      end else begin
        bus_read(VEC[i][27:16], r);
        check($sformatf("vector %0d R2/R3/R6/R8/R9", i), NPINS'(r),
              NPINS'({24'h0, VEC[i][7:0]}));
      end
    end

    // R4 R5: pins driven from the prewritten values
    check("R4 oe bank0", NPINS'(pad_oe[7:0]), NPINS'(8'hF0));
    check("R5 out bank0", NPINS'(pad_out[7:0]), NPINS'(8'hF0));
    check("R4 oe bank17", NPINS'(pad_oe[143:136]), NPINS'(8'hFF));
    check("R5 out bank16", NPINS'(pad_out[135:128]), NPINS'(8'h55));
    check("R3 window no effect", NPINS'(pad_oe[151:144]), NPINS'(8'h00));

    // R10: upper write bits ignored, upper read bits zero
    bus_write(12'h014, 32'h0);
    bus_write(12'h010, 32'hFFFF_FF5A);
    bus_read(12'h010, r);
    check("R10 low byte only", NPINS'(r), NPINS'(32'h5A));
    last = r;

    // R11: rd_data holds through a write
    bus_write(12'h010, 32'h33);
    check("R11 hold after write", NPINS'(rd_data), NPINS'(last));
    check("R5 immediate drive", NPINS'(pad_out[15:8]), NPINS'(8'h33));

    // R9: misaligned address
    bus_write(12'h011, 32'hFF);
    bus_read(12'h011, r);
    check("R9 misaligned read", NPINS'(r), '0);
    check("R9 misaligned write", NPINS'(pad_out[15:8]), NPINS'(8'h33));

    // R7: pad change collides with a held read request on bank2 (0x18)
    @(negedge clk);
    pad_in[23:16] = 8'hC3;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h018;
    @(negedge clk);
    check("R7 first edge old", NPINS'(rd_data), NPINS'(32'h3C));
    @(negedge clk);
    check("R7 second edge old", NPINS'(rd_data), NPINS'(32'h3C));
    @(negedge clk);
    check("R7 third edge new", NPINS'(rd_data), NPINS'(32'hC3));
    req_valid = 1'b0;

    // R6: direction turnaround on bank2 with stored value 0
    bus_write(12'h01C, 32'hF0);
    bus_read(12'h018, r);
    check("R6 turnaround mix", NPINS'(r), NPINS'(32'hC0));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule